// File: doc/BRIEF.md
# Return-Context Stack Sequencer

This block keeps the program stack pointer of a small 8-bit processor core. It moves the return context between the core and data RAM. The four context operations are:

- interrupt entry
- subroutine call
- subroutine return
- interrupt return

Each operation takes exactly two RAM cycles. The saved context is a 14-bit program counter plus the carry and zero flags, packed into two bytes:

- Byte 1 is the PC low byte.
- Byte 2 is `{carry, zero, PC[13:8]}`.

The stack starts at address 0x00 and grows upward. A save writes at the pointer and then increments it. A restore decrements the pointer and then reads at it. All pointer arithmetic wraps modulo 256.

The core raises one request strobe together with the PC and flags to save. The sequencer drives a byte-wide RAM port. The RAM read is asynchronous: `ram_rdata` reflects `ram_addr` in the same cycle. Restored values come back registered, with one-cycle load strobes. The sequencer also owns the global interrupt enable:

- Interrupt entry clears it.
- Interrupt return sets it.

Firmware can overwrite the pointer through a write port. Requests are control strobes, not a stream. There is no back-pressure. A request that arrives while `busy` is high is dropped, so the core must hold off until `busy` is low.

Top module: `pstack_seq`

## Requirements
- R1: After reset the pointer is 0x00 and `gie`, `busy`, `ram_we`, `pc_load` and `flags_load` are 0. The first save therefore writes address 0x00.
- R2: A call accepted at a clock edge writes PC[7:0] at pointer P in the next cycle. In the cycle after that it writes {carry, zero, PC[13:8]} (carry in bit 7, zero in bit 6) at P+1. The pointer ends at P+2.
- R3: An interrupt entry clears `gie` at the edge where it is accepted. It then performs the same two writes as R2.
- R4: An interrupt return reads address P-1 in the first cycle and P-2 in the second, and ends with the pointer at P-2. On the following cycle it presents PC = {byte(P-1)[5:0], byte(P-2)}, carry = byte(P-1) bit 7 and zero = byte(P-1) bit 6, pulses `pc_load` and `flags_load`, and sets `gie`.
- R5: A plain return reads P-1 and P-2 and pulses `pc_load` with the restored PC. `flags_load` stays low, `carry_out` and `zero_out` keep their values, and `gie` is unchanged.
- R6: `busy` is high for exactly the two cycles after acceptance. Requests and firmware pointer writes that arrive while `busy` is high have no effect.
- R7: When several requests arrive in the same idle cycle, only one is served, in the priority order interrupt entry, call, interrupt return, return.
- R8: `sp_wr` loads `sp_wdata` into the pointer only in an idle cycle with no request. If a request arrives in the same cycle, the request is served and the write is dropped.
- R9: The pointer wraps modulo 256. A save at 0xFF writes 0xFF and then 0x00. A restore at 0x01 reads 0x00 and then 0xFF.
- R10: `pc_load` is a single-cycle pulse in the cycle right after the second read. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_ack | input | 1 | Interrupt entry request |
| call_req | input | 1 | Subroutine call request |
| reti_req | input | 1 | Interrupt return request |
| ret_req | input | 1 | Subroutine return request |
| pc_in | input | 14 | Next-instruction PC to save |
| carry_in | input | 1 | Carry flag to save |
| zero_in | input | 1 | Zero flag to save |
| sp_wr | input | 1 | Firmware pointer write strobe |
| sp_wdata | input | 8 | Firmware pointer value |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read byte (same-cycle) |
| pc_out | output | 14 | Restored PC |
| carry_out | output | 1 | Restored carry flag |
| zero_out | output | 1 | Restored zero flag |
| pc_load | output | 1 | Restored PC valid pulse |
| flags_load | output | 1 | Restored flags valid pulse |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | Sequence in progress |

## Verification
A corrupted pointer cannot be read directly. It becomes visible at `ram_addr` in the first cycle of the next operation, and as a wrong restored PC one cycle after that operation's second read. A stuck or mis-stepping state machine shows up as a `busy` run that is not two cycles long, or as a RAM cycle that the scoreboard did not expect. Both appear within the operation that caused them. Swapped byte packing or a lost flag is caught when the matching return loads `pc_out`, `carry_out` and `zero_out`. The flags cases include a plain return, which must leave the flags untouched.

// File: rtl/pstack_pkg.sv
package pstack_pkg;
  typedef enum logic [1:0] {
    OP_IRQ  = 2'd0,
    OP_CALL = 2'd1,
    OP_RETI = 2'd2,
    OP_RET  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } st_e;
endpackage

// File: rtl/pstack_ctrl.sv
module pstack_ctrl
  import pstack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_ack,
  input  logic call_req,
  input  logic reti_req,
  input  logic ret_req,
  input  logic sp_wr,
  output st_e  st,
  output op_e  op,
  output logic accept,
  output logic save,
  output logic fw_load,
  output logic gie
);
  logic any_req;
  op_e  op_nxt;

  assign any_req = irq_ack | call_req | reti_req | ret_req;
  assign accept  = (st == ST_IDLE) && any_req;
  assign fw_load = (st == ST_IDLE) && !any_req && sp_wr;
  assign save    = (op == OP_IRQ) || (op == OP_CALL);

  always_comb begin
    if (irq_ack)       op_nxt = OP_IRQ;
    else if (call_req) op_nxt = OP_CALL;
    else if (reti_req) op_nxt = OP_RETI;
    else               op_nxt = OP_RET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      op  <= OP_CALL;
      gie <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st <= ST_FIRST;
          op <= op_nxt;
          if (op_nxt == OP_IRQ) gie <= 1'b0;
        end
        ST_FIRST: st <= ST_SECOND;
        ST_SECOND: begin
          st <= ST_IDLE;
          if (op == OP_RETI) gie <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pstack_ptr.sv
module pstack_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_m1
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  assign sp_m1 = sp - ONE;

  always_ff @(posedge clk) begin
    if (rst)      sp <= '0;
    else if (ld)  sp <= ld_val;
    else if (inc) sp <= sp + ONE;
    else if (dec) sp <= sp_m1;
  end
endmodule

// File: rtl/pstack_ctx.sv
module pstack_ctx #(
  parameter int PC_W   = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic              second,
  input  logic              grab_hi,
  input  logic              finish,
  input  logic              with_flags,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wbyte,
  output logic [PC_W-1:0]   pc_out,
  output logic              carry_out,
  output logic              zero_out,
  output logic              pc_load,
  output logic              flags_load
);
  localparam int HI_W = PC_W - DATA_W;

  logic [DATA_W-1:0] lo_q, hi_save_q, hi_rd_q;

  assign wbyte = second ? hi_save_q : lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q       <= '0;
      hi_save_q  <= '0;
      hi_rd_q    <= '0;
      pc_out     <= '0;
      carry_out  <= 1'b0;
      zero_out   <= 1'b0;
      pc_load    <= 1'b0;
      flags_load <= 1'b0;
    end else begin
      if (capture) begin
        lo_q      <= pc_in[DATA_W-1:0];
        hi_save_q <= {carry_in, zero_in, pc_in[PC_W-1:DATA_W]};
      end
      if (grab_hi) hi_rd_q <= rdata;
      pc_load    <= finish;
      flags_load <= finish && with_flags;
      if (finish) begin
        pc_out <= {hi_rd_q[HI_W-1:0], rdata};
        if (with_flags) begin
          carry_out <= hi_rd_q[DATA_W-1];
          zero_out  <= hi_rd_q[DATA_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/pstack_seq.sv
module pstack_seq
  import pstack_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_ack,
  input  logic              call_req,
  input  logic              reti_req,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic              sp_wr,
  input  logic [DATA_W-1:0] sp_wdata,
  output logic [DATA_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              carry_out,
  output logic              zero_out,
  output logic              pc_load,
  output logic              flags_load,
  output logic              gie,
  output logic              busy
);
  st_e  st;
  op_e  op;
  logic accept, save, fw_load, phase_save, phase_rest;
  logic [DATA_W-1:0] sp_q, sp_m1;

  pstack_ctrl u_ctrl (
    .clk(clk), .rst(rst), .irq_ack(irq_ack), .call_req(call_req),
    .reti_req(reti_req), .ret_req(ret_req), .sp_wr(sp_wr),
    .st(st), .op(op), .accept(accept), .save(save),
    .fw_load(fw_load), .gie(gie)
  );

  assign busy       = (st != ST_IDLE);
  assign phase_save = busy && save;
  assign phase_rest = busy && !save;

  pstack_ptr #(.PTR_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .inc(phase_save), .dec(phase_rest),
    .ld(fw_load), .ld_val(sp_wdata), .sp(sp_q), .sp_m1(sp_m1)
  );

  pstack_ctx #(.PC_W(PC_W), .DATA_W(DATA_W)) u_ctx (
    .clk(clk), .rst(rst), .capture(accept), .pc_in(pc_in),
    .carry_in(carry_in), .zero_in(zero_in),
    .second(st == ST_SECOND),
    .grab_hi(phase_rest && (st == ST_FIRST)),
    .finish(phase_rest && (st == ST_SECOND)),
    .with_flags(op == OP_RETI),
    .rdata(ram_rdata), .wbyte(ram_wdata), .pc_out(pc_out),
    .carry_out(carry_out), .zero_out(zero_out),
    .pc_load(pc_load), .flags_load(flags_load)
  );

  assign ram_we   = phase_save;
  assign ram_addr = save ? sp_q : sp_m1;
endmodule

// File: rtl/pstack_seq_chk.sv
module pstack_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_addr,
  input logic              pc_load,
  input logic              flags_load,
  input logic              gie,
  input logic [DATA_W-1:0] sp
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> sp == '0 && !busy && !gie);

  p_we_busy_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  p_write_step_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we && $past(ram_we) |-> ram_addr == DATA_W'($past(ram_addr) + 1'b1));

  p_ptr_inc_r9: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> sp == DATA_W'($past(sp) + 1'b1));

  p_gie_down_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(gie) |-> busy);

  p_read_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy && !ram_we && $past(busy) |-> ram_addr == DATA_W'($past(ram_addr) - 1'b1));

  p_gie_up_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gie) |-> flags_load);

  p_flags_pc_r5: assert property (@(posedge clk) disable iff (rst)
    flags_load |-> pc_load);

  p_two_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |=> !busy);

  p_load_after_r10: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> !busy && $past(busy));
endmodule

bind pstack_seq pstack_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
  .pc_load(pc_load), .flags_load(flags_load), .gie(gie), .sp(sp_q)
);

// File: tb/tb_pstack_seq.sv
`timescale 1ns/1ps
module tb_pstack_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_ack = 0, call_req = 0, reti_req = 0, ret_req = 0;
  logic [13:0] pc_in = '0;
  logic carry_in = 0, zero_in = 0, sp_wr = 0;
  logic [7:0] sp_wdata = '0;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic ram_we;
  logic [13:0] pc_out;
  logic carry_out, zero_out, pc_load, flags_load, gie, busy;

  always #2.5 clk = ~clk;

  pstack_seq dut (
    .clk(clk), .rst(rst), .irq_ack(irq_ack), .call_req(call_req),
    .reti_req(reti_req), .ret_req(ret_req), .pc_in(pc_in),
    .carry_in(carry_in), .zero_in(zero_in), .sp_wr(sp_wr),
    .sp_wdata(sp_wdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_rdata(ram_rdata), .pc_out(pc_out),
    .carry_out(carry_out), .zero_out(zero_out), .pc_load(pc_load),
    .flags_load(flags_load), .gie(gie), .busy(busy)
  );

  logic [7:0] mem [256];
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  typedef struct packed { logic we; logic [7:0] addr; logic [7:0] data; } ram_t;
  typedef struct packed { logic [13:0] pc; logic fl; logic c; logic z; logic g; } ld_t;
  ram_t ram_q[$];
  ld_t  ld_q[$];

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] msp = 8'h00;
  logic mgie = 1'b0, mc = 1'b0, mz = 1'b0;
  int run = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares RAM cycles and loads against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        run++;
        if (ram_q.size() == 0) chk(0, "R6", "unexpected busy cycle", 1, 0);
        else begin
          ram_t e;
          e = ram_q.pop_front();
          chk(ram_we == e.we, "R2", "ram_we", ram_we, e.we);
          chk(ram_addr == e.addr, "R4", "ram_addr", ram_addr, e.addr);
          if (e.we) chk(ram_wdata == e.data, "R2", "ram_wdata", ram_wdata, e.data);
        end
      end else begin
        if (run != 0) chk(run == 2, "R6", "busy length", run, 2);
        run = 0;
        if (ram_we) chk(0, "R2", "write while idle", 1, 0);
      end
      if (pc_load) begin
        if (ld_q.size() == 0) chk(0, "R10", "unexpected pc_load", 1, 0);
        else begin
          ld_t l;
          l = ld_q.pop_front();
          chk(pc_out == l.pc, "R4", "pc_out", pc_out, l.pc);
          chk(flags_load == l.fl, "R5", "flags_load", flags_load, l.fl);
          chk(carry_out == l.c, "R5", "carry_out", carry_out, l.c);
          chk(zero_out == l.z, "R5", "zero_out", zero_out, l.z);
          chk(gie == l.g, "R4", "gie", gie, l.g);
        end
      end
    end
  end

  // reqs = {irq, call, reti, ret}; noise raises other inputs while busy
  task automatic drive(input logic [3:0] reqs, input logic [13:0] pc,
                       input logic c, input logic z, input bit noise,
                       input bit fw);
    int win;
    if (reqs[3]) win = 3; else if (reqs[2]) win = 2;
    else if (reqs[1]) win = 1; else win = 0;
    if (win >= 2) begin
      ram_q.push_back({1'b1, msp, pc[7:0]});
      ram_q.push_back({1'b1, 8'(msp + 1), {c, z, pc[13:8]}});
      exp_mem[msp] = pc[7:0];
      exp_mem[8'(msp + 1)] = {c, z, pc[13:8]};
      msp = 8'(msp + 2);
      if (win == 3) mgie = 1'b0;
    end else begin
      logic [7:0] hi, lo;
      hi = exp_mem[8'(msp - 1)];
      lo = exp_mem[8'(msp - 2)];
      ram_q.push_back({1'b0, 8'(msp - 1), 8'h00});
      ram_q.push_back({1'b0, 8'(msp - 2), 8'h00});
      if (win == 1) begin mc = hi[7]; mz = hi[6]; mgie = 1'b1; end
      ld_q.push_back({{hi[5:0], lo}, (win == 1), mc, mz, mgie});
      msp = 8'(msp - 2);
    end
    @(negedge clk); #1;
    {irq_ack, call_req, reti_req, ret_req} = reqs;
    pc_in = pc; carry_in = c; zero_in = z;
    sp_wr = fw; sp_wdata = 8'h5A;
    @(negedge clk); #1;
    {irq_ack, call_req, reti_req, ret_req} = noise ? 4'b1111 : 4'b0000;
    sp_wr = noise; pc_in = 14'h3FFF;
    if (win == 3) chk(gie == 1'b0, "R3", "gie after entry", gie, 0);
    @(negedge clk); #1;
    @(negedge clk); #1;
    {irq_ack, call_req, reti_req, ret_req} = 4'b0000;
    sp_wr = 0;
    @(negedge clk); #1;
  endtask

  task automatic set_sp(input logic [7:0] v);
    @(negedge clk); #1;
    sp_wr = 1; sp_wdata = v;
    @(negedge clk); #1;
    sp_wr = 0;
    msp = v;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!busy && !gie && !ram_we && !pc_load && !flags_load, "R1", "reset outputs",
        {busy, gie, ram_we, pc_load, flags_load}, 0);
    drive(4'b0100, 14'h1234, 1, 0, 0, 0);   // R1 R2 call at 0x00
    drive(4'b1000, 14'h2ABC, 0, 1, 0, 0);   // R3 entry
    drive(4'b0010, 14'h0000, 0, 0, 0, 0);   // R4 interrupt return
    drive(4'b1000, 14'h0F0F, 1, 1, 1, 0);   // R3 R6 entry with noise while busy
    drive(4'b0010, 14'h0000, 0, 0, 1, 0);   // R4 R6
    drive(4'b0001, 14'h0000, 0, 0, 0, 0);   // R5 plain return, flags kept
    drive(4'b1111, 14'h0155, 0, 1, 0, 0);   // R7 entry wins
    drive(4'b0111, 14'h02AA, 1, 0, 0, 0);   // R7 call wins
    drive(4'b0011, 14'h0000, 0, 0, 0, 0);   // R7 interrupt return wins
    drive(4'b0001, 14'h0000, 0, 0, 0, 0);   // R5 return
    set_sp(8'hFF);                           // R8 firmware write
    drive(4'b0100, 14'h3C81, 0, 1, 0, 0);   // R9 wrap up
    drive(4'b0010, 14'h0000, 0, 0, 0, 0);   // R9 wrap down, R10
    drive(4'b0100, 14'h1111, 1, 1, 0, 1);   // R8 write dropped on collision
    drive(4'b0001, 14'h0000, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(ram_q.size() == 0, "R6", "RAM items left", ram_q.size(), 0);
    chk(ld_q.size() == 0, "R10", "loads left", ld_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog expired: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule